// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Comparator

This block watches a simplified descriptor of the processor's internal bus cycles and raises a break request when a cycle meets a condition programmed into one of two channels, A and B. Each channel compares the cycle address under a mask. Each channel can also compare the address-space identifier (ASID). Each channel filters on the cycle kind (instruction fetch or data access), the direction and the access size. Channel B can also compare the data word under a mask, and it can count its matches so that the break is taken only on the Nth one. The match flags and the break request are combinational from the presented cycle. An instruction fetch is therefore flagged in the same cycle it is presented, ahead of its execution.

The two channels work either independently or as a sequence. In the sequence, a match on A arms channel B, and only a later B match breaks. A small state machine with states `SQ_IDLE` and `SQ_ARMED` tracks the sequence. It has three transitions:
- *arm*: `SQ_IDLE` to `SQ_ARMED`, taken on an A match in sequential mode.
- *fire*: `SQ_ARMED` to `SQ_IDLE`, taken when B breaks.
- *drop*: `SQ_ARMED` to `SQ_IDLE`, taken on a write to the control register or when sequential mode is off.

Software programs the block through a word-wide register port. A read is combinational on the register index. The index map is:

| Index | Register |
|---|---|
| 0 | A address |
| 1 | A mask |
| 2 | A condition |
| 3 | B address |
| 4 | B mask |
| 5 | B condition |
| 6 | B data |
| 7 | B data mask |
| 8 | control |
| 9 | count |
| 10 | status |

Top module: `bkpt_unit`

## Requirements
- R1: A channel's address matches when every address bit whose mask bit is 0 equals the programmed address; mask bits set to 1 are ignored (mask 0x00000FFF ignores the low 12 bits).
- R2: Condition bits [1:0] select the cycle kind: 0 = channel off (never matches), 1 = fetch only, 2 = data access only, 3 = either.
- R3: Condition bits [3:2] select the direction: 1 = read only, 2 = write only, 0 or 3 = either.
- R4: Condition bits [5:4] select the size: 0 = any, 1 = byte, 2 = word, 3 = longword. The bus size input encodes 0 = byte, 1 = word, 2 = longword.
- R5: Condition bit 6 enables the ASID compare against condition bits [15:8]; when it is 0, the cycle's ASID has no effect on the match.
- R6: On channel B only, condition bit 7 enables a compare of the bus data against the B data register, with bits set in the B data mask ignored; when bit 7 is 0, the data has no effect.
- R7: The match flags and the break request rise in the same cycle as the matching bus cycle, with no register on the way.
- R8: With control bit 0 clear (independent mode), each channel's match raises the break request on its own.
- R9: With control bit 0 set (sequential mode), an A match never breaks but arms B; a B match breaks only if A matched in an earlier cycle; the arming clears when B breaks or when the control register is written.
- R10: With control bit 1 set, each qualifying B match decrements the count register (index 9); the break is raised on the match that finds the count at 1, after which the count sits at 0 and B raises no break until software reloads the count.
- R11: Status bit 0 (A) and bit 1 (B) are set by any match of that channel and stay set until software writes 1 to that bit.
- R12: After reset, all registers read 0, so both channels are off and no match or break is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | A bus cycle is presented this clock |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 = byte, 1 = word, 2 = longword |
| bus_addr | input | AW | Cycle address |
| bus_asid | input | 8 | Cycle address-space identifier |
| bus_data | input | DW | Cycle data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| match_a | output | 1 | Channel A condition met this cycle |
| match_b | output | 1 | Channel B condition met this cycle |
| brk_req | output | 1 | Break request |

## Verification
The hardest states to reach are those that depend on history.

The first is a sequential break that needs an A match in an earlier cycle. The stimulus follows a B-only cycle with an A fetch, then a cycle of the wrong kind at A's address, then two B cycles. Only the first of those two B cycles may break, because the break clears the arming. A further run checks that a control write between arming and B cancels the break.

The second is the count stop. The bench reads the count after each B match and confirms that the count sits at 0 after it fires and that no break occurs until a reload.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int ASID_W = 8;
    localparam int REG_W  = 32;
    localparam int RA_W   = 4;

    typedef enum logic [1:0] {KIND_OFF, KIND_FETCH, KIND_DATA, KIND_ANY} kind_e;
    typedef enum logic [1:0] {DIR_ANY, DIR_READ, DIR_WRITE, DIR_EITHER} dir_e;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic              data_en;
        logic              asid_en;
        logic [1:0]        size;
        dir_e              dir;
        kind_e             kind;
    } cond_t;

    localparam int COND_W = $bits(cond_t);

    localparam logic [RA_W-1:0] RX_A_ADDR = 4'd0;
    localparam logic [RA_W-1:0] RX_A_MASK = 4'd1;
    localparam logic [RA_W-1:0] RX_A_COND = 4'd2;
    localparam logic [RA_W-1:0] RX_B_ADDR = 4'd3;
    localparam logic [RA_W-1:0] RX_B_MASK = 4'd4;
    localparam logic [RA_W-1:0] RX_B_COND = 4'd5;
    localparam logic [RA_W-1:0] RX_B_DATA = 4'd6;
    localparam logic [RA_W-1:0] RX_B_DMSK = 4'd7;
    localparam logic [RA_W-1:0] RX_CTRL   = 4'd8;
    localparam logic [RA_W-1:0] RX_COUNT  = 4'd9;
    localparam logic [RA_W-1:0] RX_STAT   = 4'd10;

    typedef enum logic {SQ_IDLE, SQ_ARMED} seq_e;
endpackage

// File: rtl/bkpt_chan.sv
module bkpt_chan
    import bkpt_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter bit HAS_DATA = 1'b0
) (
    input  logic              bus_valid,
    input  logic              bus_fetch,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [AW-1:0]     bus_addr,
    input  logic [ASID_W-1:0] bus_asid,
    input  logic [DW-1:0]     bus_data,
    input  logic [AW-1:0]     cmp_addr,
    input  logic [AW-1:0]     cmp_mask,
    input  cond_t             cond,
    input  logic [DW-1:0]     cmp_data,
    input  logic [DW-1:0]     data_mask,
    output logic              hit
);
    logic kind_ok, dir_ok, size_ok, asid_ok, addr_ok, data_ok;

    always_comb begin
        unique case (cond.kind)
            KIND_OFF:   kind_ok = 1'b0;
            KIND_FETCH: kind_ok = bus_fetch;
            KIND_DATA:  kind_ok = !bus_fetch;
            KIND_ANY:   kind_ok = 1'b1;
        endcase
        unique case (cond.dir)
            DIR_READ:  dir_ok = !bus_write;
            DIR_WRITE: dir_ok = bus_write;
            DIR_ANY,
            DIR_EITHER: dir_ok = 1'b1;
        endcase
        size_ok = (cond.size == 2'd0) || (cond.size == 2'(bus_size + 2'd1));
        asid_ok = !cond.asid_en || (cond.asid == bus_asid);
        addr_ok = ((bus_addr ^ cmp_addr) & ~cmp_mask) == '0;
        data_ok = HAS_DATA ? (!cond.data_en || (((bus_data ^ cmp_data) & ~data_mask) == '0))
                           : 1'b1;
        hit = bus_valid && kind_ok && dir_ok && size_ok && asid_ok && addr_ok && data_ok;
    end

    always_comb begin
        if (hit) begin
            AST_OFF_NEVER_HITS: assert (cond.kind != KIND_OFF); // R2
        end
    end
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             hit_a,
    input  logic             hit_b,
    input  logic [CW-1:0]    cnt_q,
    output logic [AW-1:0]    a_addr,
    output logic [AW-1:0]    a_mask,
    output cond_t            a_cond,
    output logic [AW-1:0]    b_addr,
    output logic [AW-1:0]    b_mask,
    output cond_t            b_cond,
    output logic [DW-1:0]    b_data,
    output logic [DW-1:0]    b_dmsk,
    output logic             seq_mode,
    output logic             cnt_en,
    output logic             ctrl_wr,
    output logic             cnt_load,
    output logic [CW-1:0]    cnt_wval
);
    logic [1:0] ctrl_q;
    logic [1:0] stat_q;

    assign seq_mode = ctrl_q[0];
    assign cnt_en   = ctrl_q[1];
    assign ctrl_wr  = reg_we && (reg_addr == RX_CTRL);
    assign cnt_load = reg_we && (reg_addr == RX_COUNT);
    assign cnt_wval = reg_wdata[CW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_addr <= '0;
            a_mask <= '0;
            a_cond <= '0;
            b_addr <= '0;
            b_mask <= '0;
            b_cond <= '0;
            b_data <= '0;
            b_dmsk <= '0;
            ctrl_q <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                RX_A_ADDR: a_addr <= reg_wdata[AW-1:0];
                RX_A_MASK: a_mask <= reg_wdata[AW-1:0];
                RX_A_COND: a_cond <= cond_t'(reg_wdata[COND_W-1:0]);
                RX_B_ADDR: b_addr <= reg_wdata[AW-1:0];
                RX_B_MASK: b_mask <= reg_wdata[AW-1:0];
                RX_B_COND: b_cond <= cond_t'(reg_wdata[COND_W-1:0]);
                RX_B_DATA: b_data <= reg_wdata[DW-1:0];
                RX_B_DMSK: b_dmsk <= reg_wdata[DW-1:0];
                RX_CTRL:   ctrl_q <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if ((i == 0) ? hit_a : hit_b) begin
                    stat_q[i] <= 1'b1;
                end else if (reg_we && (reg_addr == RX_STAT) && reg_wdata[i]) begin
                    stat_q[i] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RX_A_ADDR: reg_rdata[AW-1:0]     = a_addr;
            RX_A_MASK: reg_rdata[AW-1:0]     = a_mask;
            RX_A_COND: reg_rdata[COND_W-1:0] = a_cond;
            RX_B_ADDR: reg_rdata[AW-1:0]     = b_addr;
            RX_B_MASK: reg_rdata[AW-1:0]     = b_mask;
            RX_B_COND: reg_rdata[COND_W-1:0] = b_cond;
            RX_B_DATA: reg_rdata[DW-1:0]     = b_data;
            RX_B_DMSK: reg_rdata[DW-1:0]     = b_dmsk;
            RX_CTRL:   reg_rdata[1:0]        = ctrl_q;
            RX_COUNT:  reg_rdata[CW-1:0]     = cnt_q;
            RX_STAT:   reg_rdata[1:0]        = stat_q;
            default: ;
        endcase
    end

    AST_STICKY_A: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> stat_q[0]); // R11
    AST_STICKY_B: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |=> stat_q[1]); // R11
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_a && !hit_b && !(reg_we && reg_addr == RX_STAT)) |=> $stable(stat_q)); // R11
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
    import bkpt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seq_mode,
    input  logic          cnt_en,
    input  logic          hit_a,
    input  logic          hit_b,
    input  logic          ctrl_wr,
    input  logic          cnt_load,
    input  logic [CW-1:0] cnt_wval,
    output logic          brk_req,
    output logic [CW-1:0] cnt_q
);
    seq_e    state_q, state_d;
    logic    b_qual, brk_a, brk_b;
    logic    cnt_step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        b_qual   = hit_b && (!seq_mode || (state_q == SQ_ARMED));
        brk_a    = hit_a && !seq_mode;
        brk_b    = b_qual && (!cnt_en || (cnt_q == CW'(1)));
        cnt_step = cnt_en && b_qual && (cnt_q != '0);
        brk_req  = brk_a || brk_b;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (seq_mode && hit_a) state_d = SQ_ARMED;
            SQ_ARMED: if (brk_b || !seq_mode) state_d = SQ_IDLE;
        endcase
        if (ctrl_wr) state_d = SQ_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_load) begin
            cnt_q <= cnt_wval;
        end else if (cnt_step) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    AST_ARM_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_ARMED && $past(state_q) == SQ_IDLE) |-> $past(hit_a)); // R9
    AST_SEQ_BRK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode && brk_req) |-> (state_q == SQ_ARMED && hit_b)); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && b_qual && !cnt_load && cnt_q != '0) |=> (cnt_q == CW'($past(cnt_q) - 1'b1))); // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_load && !(cnt_en && hit_b)) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_fetch,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [AW-1:0]     bus_addr,
    input  logic [ASID_W-1:0] bus_asid,
    input  logic [DW-1:0]     bus_data,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              match_a,
    output logic              match_b,
    output logic              brk_req
);
    logic [AW-1:0] a_addr, a_mask, b_addr, b_mask;
    logic [DW-1:0] b_data, b_dmsk;
    cond_t         a_cond, b_cond;
    logic          seq_mode, cnt_en, ctrl_wr, cnt_load;
    logic [CW-1:0] cnt_wval, cnt_q;
    logic          hit_a, hit_b;

    bkpt_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hit_a(hit_a), .hit_b(hit_b), .cnt_q(cnt_q),
        .a_addr(a_addr), .a_mask(a_mask), .a_cond(a_cond),
        .b_addr(b_addr), .b_mask(b_mask), .b_cond(b_cond),
        .b_data(b_data), .b_dmsk(b_dmsk),
        .seq_mode(seq_mode), .cnt_en(cnt_en), .ctrl_wr(ctrl_wr),
        .cnt_load(cnt_load), .cnt_wval(cnt_wval)
    );

    bkpt_chan #(.AW(AW), .DW(DW), .HAS_DATA(1'b0)) u_chan_a (
        .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_asid(bus_asid), .bus_data(bus_data),
        .cmp_addr(a_addr), .cmp_mask(a_mask), .cond(a_cond),
        .cmp_data('0), .data_mask('0), .hit(hit_a)
    );

    bkpt_chan #(.AW(AW), .DW(DW), .HAS_DATA(1'b1)) u_chan_b (
        .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_asid(bus_asid), .bus_data(bus_data),
        .cmp_addr(b_addr), .cmp_mask(b_mask), .cond(b_cond),
        .cmp_data(b_data), .data_mask(b_dmsk), .hit(hit_b)
    );

    bkpt_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .seq_mode(seq_mode), .cnt_en(cnt_en),
        .hit_a(hit_a), .hit_b(hit_b),
        .ctrl_wr(ctrl_wr), .cnt_load(cnt_load), .cnt_wval(cnt_wval),
        .brk_req(brk_req), .cnt_q(cnt_q)
    );

    assign match_a = hit_a;
    assign match_b = hit_b;

    AST_BRK_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (match_a || match_b)); // R8
    AST_NO_HIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (!match_a && !match_b && !brk_req)); // R7
endmodule

// File: tb/bkpt_unit_bench.sv
`timescale 1ns/1ps
module bkpt_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_asid = '0;
    logic [31:0] bus_data = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        match_a, match_b, brk_req;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic ga, gb, gk;
    logic [31:0] rv;

    always #5 clk = ~clk;

    bkpt_unit u_bkpt_unit (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
        .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_asid(bus_asid), .bus_data(bus_data), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .match_a(match_a), .match_b(match_b), .brk_req(brk_req)
    );

    typedef struct packed {
        logic        f;
        logic        w;
        logic [1:0]  sz;
        logic [31:0] a;
        logic [7:0]  id;
        logic [31:0] d;
        logic        ma;
        logic        mb;
        logic        bk;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b0, 2'd2, 32'h0000_8000, 8'h80, 32'h0,          1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 2'd2, 32'h0000_8FFC, 8'h80, 32'h0,          1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 2'd2, 32'h0000_9000, 8'h80, 32'h0,          1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 2'd2, 32'h0000_8404, 8'h81, 32'h0,          1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 2'd1, 32'h0000_1000, 8'h12, 32'h1234_55AA,  1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b1, 2'd1, 32'h0000_1000, 8'h12, 32'h0000_55AB,  1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 2'd1, 32'h0000_1000, 8'h12, 32'h0000_55AA,  1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 2'd2, 32'h0000_1000, 8'h12, 32'h0000_55AA,  1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 2'd1, 32'h0000_1002, 8'h12, 32'h0000_55AA,  1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 2'd1, 32'h0000_8404, 8'h80, 32'h0,          1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        reg_addr = a;
        #1 rv = reg_rdata;
    endtask

    task automatic cyc(input logic f, input logic w, input logic [1:0] sz,
                       input logic [31:0] a, input logic [7:0] id, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_fetch = f; bus_write = w; bus_size = sz;
        bus_addr = a; bus_asid = id; bus_data = d;
        #1 ga = match_a; gb = match_b; gk = brk_req;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12: reset state
        rd(4'd2);  chk("R12 a_cond reset", rv, 32'h0);
        rd(4'd9);  chk("R12 count reset", rv, 32'h0);
        rd(4'd10); chk("R12 status reset", rv, 32'h0);
        cyc(1'b1, 1'b0, 2'd2, 32'h0, 8'h0, 32'h0);
        chk("R12 no match after reset", {29'h0, ga, gb, gk}, 32'h0);

        // independent mode table
        wr(4'd0, 32'h0000_8404); wr(4'd1, 32'h0000_0FFF); wr(4'd2, 32'h0000_8041);
        wr(4'd3, 32'h0000_1000); wr(4'd4, 32'h0);        wr(4'd5, 32'h0000_00AA);
        wr(4'd6, 32'h0000_55AA); wr(4'd7, 32'hFFFF_0000); wr(4'd8, 32'h0);
        for (int i = 0; i < NV; i++) begin
            cyc(VT[i].f, VT[i].w, VT[i].sz, VT[i].a, VT[i].id, VT[i].d);
            chk($sformatf("R1 R3 R4 R5 R6 match_a vec%0d", i), {31'h0, ga}, {31'h0, VT[i].ma});
            chk($sformatf("R2 R6 match_b vec%0d", i), {31'h0, gb}, {31'h0, VT[i].mb});
            chk($sformatf("R7 R8 brk vec%0d", i), {31'h0, gk}, {31'h0, VT[i].bk});
        end

        // R11 sticky status
        rd(4'd10); chk("R11 both sticky", rv, 32'h3);
        wr(4'd10, 32'h1);
        rd(4'd10); chk("R11 clear A only", rv, 32'h2);
        wr(4'd10, 32'h2);
        rd(4'd10); chk("R11 clear B", rv, 32'h0);

        // R5 ASID disabled
        wr(4'd2, 32'h0000_8001);
        cyc(1'b1, 1'b0, 2'd2, 32'h0000_8404, 8'h33, 32'h0);
        chk("R5 asid ignored", {31'h0, ga}, 32'h1);

        // R2 kind any / off
        wr(4'd2, 32'h0000_0003);
        cyc(1'b0, 1'b1, 2'd0, 32'h0000_8404, 8'h0, 32'h0);
        chk("R2 kind any data write", {31'h0, ga}, 32'h1);
        wr(4'd2, 32'h0000_0000);
        cyc(1'b1, 1'b0, 2'd2, 32'h0000_8404, 8'h0, 32'h0);
        chk("R2 kind off", {31'h0, ga}, 32'h0);

        // R6 data compare disabled
        wr(4'd5, 32'h0000_002A);
        cyc(1'b0, 1'b1, 2'd1, 32'h0000_1000, 8'h0, 32'hFFFF_FFFF);
        chk("R6 data ignored", {31'h0, gb}, 32'h1);

        // R9 sequential mode
        wr(4'd0, 32'h0000_0500); wr(4'd1, 32'h0); wr(4'd2, 32'h0000_0001);
        wr(4'd5, 32'h0000_000A); wr(4'd8, 32'h1);
        cyc(1'b0, 1'b1, 2'd2, 32'h0000_1000, 8'h0, 32'h0);
        chk("R9 B before A match", {30'h0, gb, gk}, 32'h2);
        cyc(1'b1, 1'b0, 2'd2, 32'h0000_0500, 8'h0, 32'h0);
        chk("R9 A arms without break", {30'h0, ga, gk}, 32'h2);
        cyc(1'b0, 1'b0, 2'd2, 32'h0000_0500, 8'h0, 32'h0);
        chk("R9 wrong kind on A", {29'h0, ga, gb, gk}, 32'h0);
        cyc(1'b0, 1'b1, 2'd2, 32'h0000_1000, 8'h0, 32'h0);
        chk("R9 B after A breaks", {31'h0, gk}, 32'h1);
        cyc(1'b0, 1'b1, 2'd2, 32'h0000_1000, 8'h0, 32'h0);
        chk("R9 arming cleared by break", {30'h0, gb, gk}, 32'h2);
        cyc(1'b1, 1'b0, 2'd2, 32'h0000_0500, 8'h0, 32'h0);
        wr(4'd8, 32'h1);
        cyc(1'b0, 1'b1, 2'd2, 32'h0000_1000, 8'h0, 32'h0);
        chk("R9 control write drops arming", {31'h0, gk}, 32'h0);

        // R10 execution count, independent mode
        wr(4'd8, 32'h2); wr(4'd9, 32'h3);
        cyc(1'b0, 1'b1, 2'd2, 32'h0000_1000, 8'h0, 32'h0);
        chk("R10 first of three", {31'h0, gk}, 32'h0);
        rd(4'd9); chk("R10 count after one", rv, 32'h2);
        cyc(1'b0, 1'b1, 2'd2, 32'h0000_1000, 8'h0, 32'h0);
        chk("R10 second of three", {31'h0, gk}, 32'h0);
        cyc(1'b0, 1'b1, 2'd2, 32'h0000_1000, 8'h0, 32'h0);
        chk("R10 third breaks", {31'h0, gk}, 32'h1);
        rd(4'd9); chk("R10 count stopped", rv, 32'h0);
        cyc(1'b0, 1'b1, 2'd2, 32'h0000_1000, 8'h0, 32'h0);
        chk("R10 no break after stop", {30'h0, gb, gk}, 32'h2);
        wr(4'd9, 32'h1);
        cyc(1'b0, 1'b1, 2'd2, 32'h0000_1000, 8'h0, 32'h0);
        chk("R10 reload to one breaks", {31'h0, gk}, 32'h1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule